// File: doc/BRIEF.md
# Token-Chained TDM Sample Sender

This block drives one synchronous serial link that is shared by several sample channels. Channel 0 leads the chain and the others follow in fixed order. A token says which channel owns the link. The owner raises frame sync for one bit period, shifts out a 16-bit word MSB first, and passes the token on. The next channel raises its own frame sync in the bit period right after that LSB. Once the last channel has sent its word, the link idles until the round period runs out. The token then goes back to channel 0, which opens the next round.

Each outgoing word holds a 14-bit two's complement sample in its upper bits and a 2-bit origin tag in its lowest bits. The sample comes from a parallel input per channel. Receive and transmit share the one frame sync. While a channel owns the link, it collects the word arriving on the serial input and presents its upper 14 bits on that channel's playback output.

The bit rate divided by the round length in bit periods gives the per-channel sample rate. With the default round of 72 bit periods, a bit rate of 576 kbit/s yields 8 kHz per channel.

The controller is a four-state machine:
- IDLE: after reset, waiting for start.
- SYNC: the frame sync bit.
- SHIFT: the 16 data bits.
- GAP: idle tail of the round.

Its transitions are named as follows:
- T_LAUNCH: IDLE to SYNC, when start is seen.
- T_MSB: SYNC to SHIFT.
- T_HANDOFF: SHIFT to SYNC, passing the token to the next channel.
- T_RETURN: SHIFT to SYNC back at channel 0, when the round is exactly full.
- T_PARK: SHIFT to GAP.
- T_RESUME: GAP to SYNC at channel 0.

Top module: `tdm_token_chain`

## Requirements
- R1: A synchronous reset drives `fs`, `sdo`, `sclk` and every playback output to 0 and parks the token at channel 0. No frame sync appears while `start` stays low.
- R2: The first frame sync, owned by channel 0, begins at the first bit clock rising edge at which `start` is high. After that, `start` has no further effect.
- R3: `fs` is high for exactly one bit period, immediately before the MSB of a word. `sdo` is 0 while `fs` is high and during the idle tail of a round.
- R4: Every word is 16 bits, sent MSB first. Bits [15:2] carry the owner's 14-bit sample as captured at the start of the round. Bits [1:0] are 2'b00 when channel 0 sends and 2'b01 when any other channel sends.
- R5: Channels send in order 0, 1, 2, 3 within each round. Each later channel's frame sync falls in the bit period directly after the previous LSB, so slot starts are 17 bit periods apart.
- R6: Channel 0's frame sync recurs every ROUND_BITS bit periods (default 72). All sample inputs are captured at the rising edge that starts channel 0's frame sync.
- R7: `fs` and `sdo` change only with a rising edge of `sclk`. `sdi` is sampled on the falling edge of `sclk`.
- R8: When a channel's slot ends, that channel's playback output takes bits [15:2] of the word received on `sdi` during the slot. Received bits [1:0] are ignored, and the other channels' playback outputs do not change.
- R9: `sclk` runs freely from reset with a period of 2*HALF_CLKS cycles of `clk` (default 4). It first rises HALF_CLKS cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Level that lets the first round begin |
| sample_in | input | NCH*SAMP_W (56) | Parallel samples, channel c at bits [c*14 +: 14] |
| sdi | input | 1 | Serial data in (playback words) |
| sclk | output | 1 | Bit clock |
| fs | output | 1 | Shared frame sync |
| sdo | output | 1 | Serial data out |
| play_out | output | NCH*SAMP_W (56) | Playback samples, channel c at bits [c*14 +: 14] |

## Verification
The bench puts extreme sample values on the link: the most positive, the most negative, zero and all ones. A design that mixed up tag and sample bits, or that sent them LSB first, would corrupt these words. Received words carry nonzero low bits, so a design that kept the tag bits, or that sampled `sdi` on the rising edge, would show shifted or wrong playback values. Slot spacing and round spacing are measured in bit periods, which catches a hand-off that is one bit late or a round that restarts at the wrong moment. Dropping `start` mid-run and checking the idle and reset behaviour catches a controller that stops without cause or that sends frame sync before it is enabled.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } tdm_state_t;

    localparam int          TAG_W      = 2;
    localparam logic [1:0]  TAG_MASTER = 2'b00;
    localparam logic [1:0]  TAG_SLAVE  = 2'b01;
endpackage

// File: rtl/tdm_bitclk.sv
module tdm_bitclk #(
    parameter int HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF_CLKS - 1));
    assign rise_tick = wrap & ~sclk;
    assign fall_tick = wrap & sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_sequencer.sv
module tdm_sequencer
    import tdm_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int WORD_W     = 16,
    parameter int ROUND_BITS = 72
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      rise_tick,
    output logic                      fs,
    output logic                      idle,
    output logic                      latch,
    output logic [NCH-1:0]            cur_token,
    output logic                      cur_shift,
    output logic [$clog2(WORD_W)-1:0] cur_bit,
    output logic [NCH-1:0]            nxt_token,
    output logic                      nxt_shift,
    output logic [$clog2(WORD_W)-1:0] nxt_bit
);
    localparam int BW = $clog2(WORD_W);
    localparam int RW = $clog2(ROUND_BITS);

    tdm_state_t     state, state_n;
    logic [NCH-1:0] token, token_n;
    logic [BW-1:0]  bit_idx, bit_idx_n;
    logic [RW-1:0]  round_cnt, round_cnt_n;
    logic           round_wrap;
    logic [RW-1:0]  round_step;

    assign round_wrap = (round_cnt == RW'(ROUND_BITS - 1));
    assign round_step = round_wrap ? '0 : round_cnt + 1'b1;

    // next-state logic
    always_comb begin
        state_n     = state;
        token_n     = token;
        bit_idx_n   = bit_idx;
        round_cnt_n = round_cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin                       // T_LAUNCH
                    state_n     = ST_SYNC;
                    token_n     = NCH'(1);
                    round_cnt_n = '0;
                end
            end
            ST_SYNC: begin                             // T_MSB
                state_n     = ST_SHIFT;
                bit_idx_n   = BW'(WORD_W - 1);
                round_cnt_n = round_step;
            end
            ST_SHIFT: begin
                round_cnt_n = round_step;
                if (bit_idx == '0) begin
                    if (!token[NCH-1]) begin           // T_HANDOFF
                        state_n = ST_SYNC;
                        token_n = {token[NCH-2:0], token[NCH-1]};
                    end else if (round_wrap) begin     // T_RETURN
                        state_n = ST_SYNC;
                        token_n = NCH'(1);
                    end else begin                     // T_PARK
                        state_n = ST_GAP;
                    end
                end else begin
                    bit_idx_n = bit_idx - 1'b1;
                end
            end
            ST_GAP: begin
                round_cnt_n = round_step;
                if (round_wrap) begin                  // T_RESUME
                    state_n = ST_SYNC;
                    token_n = NCH'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            token     <= NCH'(1);
            bit_idx   <= '0;
            round_cnt <= '0;
        end else if (rise_tick) begin
            state     <= state_n;
            token     <= token_n;
            bit_idx   <= bit_idx_n;
            round_cnt <= round_cnt_n;
        end
    end

    // registered outputs, changing only with the bit clock rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            fs <= 1'b0;
        end else if (rise_tick) begin
            fs <= (state_n == ST_SYNC);
        end
    end

    assign idle      = (state == ST_IDLE);
    assign latch     = rise_tick && (state_n == ST_SYNC) && token_n[0];
    assign cur_token = token;
    assign cur_shift = (state == ST_SHIFT);
    assign cur_bit   = bit_idx;
    assign nxt_token = token_n;
    assign nxt_shift = (state_n == ST_SHIFT);
    assign nxt_bit   = bit_idx_n;
endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
    import tdm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int SAMP_W = 14
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rise_tick,
    input  logic                            fall_tick,
    input  logic                            latch,
    input  logic [NCH*SAMP_W-1:0]           sample_in,
    input  logic                            sdi,
    input  logic [NCH-1:0]                  cur_token,
    input  logic                            cur_shift,
    input  logic [$clog2(SAMP_W+TAG_W)-1:0] cur_bit,
    input  logic [NCH-1:0]                  nxt_token,
    input  logic                            nxt_shift,
    input  logic [$clog2(SAMP_W+TAG_W)-1:0] nxt_bit,
    output logic                            sdo,
    output logic [NCH*SAMP_W-1:0]           play_out
);
    localparam int WORD_W = SAMP_W + TAG_W;

    logic [NCH-1:0][SAMP_W-1:0] samp_q;
    logic [NCH-1:0][WORD_W-1:0] tx_word;
    logic [WORD_W-1:0]          sel_word;
    logic [WORD_W-2:0]          rx_sr;
    logic [WORD_W-1:0]          rx_full;
    logic                       slot_end;

    // samples captured once per round, at channel 0's frame sync
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
        end else if (latch) begin
            samp_q <= sample_in;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_word
        if (g == 0) begin : g_master
            assign tx_word[g] = {samp_q[g], TAG_MASTER};
        end else begin : g_slave
            assign tx_word[g] = {samp_q[g], TAG_SLAVE};
        end
    end

    always_comb begin
        sel_word = '0;
        for (int c = 0; c < NCH; c++) begin
            if (nxt_token[c]) begin
                sel_word = sel_word | tx_word[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo <= 1'b0;
        end else if (rise_tick) begin
            sdo <= nxt_shift ? sel_word[nxt_bit] : 1'b0;
        end
    end

    // receive path, sampled on the bit clock falling edge
    assign rx_full  = {rx_sr, sdi};
    assign slot_end = fall_tick && cur_shift && (cur_bit == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr <= '0;
        end else if (fall_tick && cur_shift) begin
            rx_sr <= rx_full[WORD_W-2:0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_play
        logic [SAMP_W-1:0] play_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                play_q <= '0;
            end else if (slot_end && cur_token[g]) begin
                play_q <= rx_full[WORD_W-1 -: SAMP_W];
            end
        end
        assign play_out[g*SAMP_W +: SAMP_W] = play_q;
    end
endmodule

// File: rtl/tdm_token_chain.sv
module tdm_token_chain
    import tdm_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int SAMP_W     = 14,
    parameter int HALF_CLKS  = 2,
    parameter int ROUND_BITS = 72
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NCH*SAMP_W-1:0] sample_in,
    input  logic                  sdi,
    output logic                  sclk,
    output logic                  fs,
    output logic                  sdo,
    output logic [NCH*SAMP_W-1:0] play_out
);
    localparam int WORD_W = SAMP_W + TAG_W;
    localparam int BW     = $clog2(WORD_W);

    logic           rise_tick, fall_tick;
    logic           seq_idle, latch;
    logic [NCH-1:0] token, nxt_token;
    logic           cur_shift, nxt_shift;
    logic [BW-1:0]  cur_bit, nxt_bit;

    tdm_bitclk #(.HALF_CLKS(HALF_CLKS)) u_bitclk (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    tdm_sequencer #(
        .NCH        (NCH),
        .WORD_W     (WORD_W),
        .ROUND_BITS (ROUND_BITS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rise_tick (rise_tick),
        .fs        (fs),
        .idle      (seq_idle),
        .latch     (latch),
        .cur_token (token),
        .cur_shift (cur_shift),
        .cur_bit   (cur_bit),
        .nxt_token (nxt_token),
        .nxt_shift (nxt_shift),
        .nxt_bit   (nxt_bit)
    );

    tdm_datapath #(
        .NCH    (NCH),
        .SAMP_W (SAMP_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .latch     (latch),
        .sample_in (sample_in),
        .sdi       (sdi),
        .cur_token (token),
        .cur_shift (cur_shift),
        .cur_bit   (cur_bit),
        .nxt_token (nxt_token),
        .nxt_shift (nxt_shift),
        .nxt_bit   (nxt_bit),
        .sdo       (sdo),
        .play_out  (play_out)
    );
endmodule

// File: rtl/tdm_token_chain_chk.sv
module tdm_token_chain_chk #(
    parameter int NCH        = 4,
    parameter int SAMP_W     = 14,
    parameter int ROUND_BITS = 72
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  fs,
    input logic                  sdo,
    input logic                  sclk,
    input logic [NCH*SAMP_W-1:0] play_out,
    input logic                  rise_tick,
    input logic                  fall_tick,
    input logic [NCH-1:0]        token,
    input logic                  in_idle
);
    logic fs_q;
    logic seen_master;
    int   bits_since;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q        <= 1'b0;
            seen_master <= 1'b0;
            bits_since  <= 0;
        end else begin
            fs_q <= fs;
            if (fs && !fs_q && token[0]) begin
                seen_master <= 1'b1;
                bits_since  <= 0;
            end else if (rise_tick) begin
                bits_since <= bits_since + 1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        in_idle |-> (!fs && !sdo));                                   // R1
    AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (fs && rise_tick) |=> !fs);                                   // R3
    AST_FS_SDO_LOW: assert property (@(posedge clk) disable iff (rst)
        fs |-> !sdo);                                                 // R3
    AST_TOKEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $countones(token) == 1);                                      // R5
    AST_ROUND_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (fs && !fs_q && token[0] && seen_master) |-> (bits_since == ROUND_BITS)); // R6
    AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        !rise_tick |=> ($stable(fs) && $stable(sdo)));                // R7
    AST_PLAY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall_tick |=> $stable(play_out));                            // R8
    AST_SCLK_RISE: assert property (@(posedge clk) disable iff (rst)
        rise_tick |=> sclk);                                          // R9
    AST_SCLK_FALL: assert property (@(posedge clk) disable iff (rst)
        fall_tick |=> !sclk);                                         // R9
endmodule

bind tdm_token_chain tdm_token_chain_chk #(
    .NCH        (NCH),
    .SAMP_W     (SAMP_W),
    .ROUND_BITS (ROUND_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fs        (fs),
    .sdo       (sdo),
    .sclk      (sclk),
    .play_out  (play_out),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .token     (token),
    .in_idle   (seq_idle)
);

// File: tb/tdm_token_chain_tb.sv
module tdm_token_chain_tb;
    localparam int NCH        = 4;
    localparam int SAMP_W     = 14;
    localparam int WORD_W     = 16;
    localparam int HALF_CLKS  = 2;
    localparam int ROUND_BITS = 72;
    localparam int SLOT       = WORD_W + 1;
    localparam int NR         = 8;

    typedef struct packed {
        logic [7:0]  rnd;
        logic [7:0]  ch;
        logic [15:0] word;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sdi = 1'b0;
    logic [NCH*SAMP_W-1:0] sample_in = '0;
    logic sclk, fs, sdo;
    logic [NCH*SAMP_W-1:0] play_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    item_t exp_q[$];
    logic [NCH*SAMP_W-1:0] exp_play = '0;

    // monitor state
    int   slot_total = 0;
    int   master_count = 0;
    int   words_done = 0;
    int   stable_bad = 0;
    int   spacing_bad = 0;
    int   gap_sdo_bad = 0;
    int   fs_data_bad = 0;

    always #2 clk = ~clk;

    tdm_token_chain #(
        .NCH(NCH), .SAMP_W(SAMP_W), .HALF_CLKS(HALF_CLKS), .ROUND_BITS(ROUND_BITS)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .sample_in(sample_in), .sdi(sdi),
        .sclk(sclk), .fs(fs), .sdo(sdo), .play_out(play_out)
    );

    function automatic logic [SAMP_W-1:0] samp_of(int r, int c);
        if (r == 0) begin
            case (c)
                0:       return 14'h1FFF;
                1:       return 14'h2000;
                2:       return 14'h0000;
                default: return 14'h3FFF;
            endcase
        end
        return SAMP_W'(r * 2877 + c * 5489 + 291);
    endfunction

    function automatic logic [15:0] rx_word(int r, int c);
        return 16'(r * 40503 + c * 9029 + 17) ^ 16'h5A3D;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_round(int r);
        for (int c = 0; c < NCH; c++) begin
            item_t it;
            logic [SAMP_W-1:0] s;
            s = samp_of(r, c);
            sample_in[c*SAMP_W +: SAMP_W] = s;
            it.rnd  = 8'(r);
            it.ch   = 8'(c);
            it.word = {s, (c == 0) ? 2'b00 : 2'b01};
            exp_q.push_back(it);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // monitor: pops expected words as the design shifts them out, drives sdi
    initial begin
        logic        sclk_prev = 1'b0;
        logic        prev_fs = 1'b0;
        logic        prev_sdo = 1'b0;
        bit          seen_rise = 1'b0;
        bit          collecting = 1'b0;
        bit          pending = 1'b0;
        int          gap = 0;
        int          bitcnt = 0;
        int          dcount = 0;
        int          cur_ch = 0;
        int          cur_rnd = 0;
        int          last_fs = 0;
        int          last_master = 0;
        logic [15:0] rword = '0;
        logic [15:0] rw;
        item_t       it;
        forever begin
            @(negedge clk);
            if (rst) begin
                sclk_prev = 1'b0;
                prev_fs   = 1'b0;
                prev_sdo  = 1'b0;
                seen_rise = 1'b0;
                gap       = 0;
            end else begin
                gap++;
                if (!(sclk && !sclk_prev)) begin
                    if (fs !== prev_fs || sdo !== prev_sdo) stable_bad++;
                end else begin
                    if (seen_rise && gap != 2*HALF_CLKS) spacing_bad++;
                    seen_rise = 1'b1;
                    gap = 0;
                    bitcnt++;
                    if (pending) begin
                        pending = 1'b0;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R5", "unexpected word", 64'(rword), 64'(0));
                        end else begin
                            it = exp_q.pop_front();
                            check(it.ch == 8'(cur_ch) && it.rnd == 8'(cur_rnd), "R5",
                                  "slot owner", 64'(cur_ch), 64'(it.ch));
                            check(rword == it.word, "R4", "transmitted word",
                                  64'(rword), 64'(it.word));
                        end
                        rw = rx_word(cur_rnd, cur_ch);
                        exp_play[cur_ch*SAMP_W +: SAMP_W] = rw[15:2];
                        check(play_out == exp_play, "R8", "playback outputs",
                              64'(play_out), 64'(exp_play));
                        words_done++;
                    end
                    if (collecting) begin
                        if (fs) fs_data_bad++;
                        rword = {rword[14:0], sdo};
                        rw = rx_word(cur_rnd, cur_ch);
                        sdi = rw[15-dcount];
                        dcount++;
                        if (dcount == WORD_W) begin
                            collecting = 1'b0;
                            pending = 1'b1;
                        end
                    end else if (fs) begin
                        cur_ch  = slot_total % NCH;
                        cur_rnd = slot_total / NCH;
                        slot_total++;
                        if (cur_ch == 0) begin
                            if (master_count > 0)
                                check(bitcnt - last_master == ROUND_BITS, "R6",
                                      "round spacing", 64'(bitcnt - last_master), 64'(ROUND_BITS));
                            last_master = bitcnt;
                            master_count++;
                        end else begin
                            check(bitcnt - last_fs == SLOT, "R5", "hand-off spacing",
                                  64'(bitcnt - last_fs), 64'(SLOT));
                        end
                        check(sdo == 1'b0, "R3", "sdo during frame sync", 64'(sdo), 64'(0));
                        last_fs = bitcnt;
                        collecting = 1'b1;
                        dcount = 0;
                    end else begin
                        if (sdo) gap_sdo_bad++;
                    end
                end
                prev_fs   = fs;
                prev_sdo  = sdo;
                sclk_prev = sclk;
            end
        end
    end

    // driver
    initial begin
        repeat (4) @(negedge clk);
        check(fs == 1'b0 && sdo == 1'b0 && sclk == 1'b0, "R1", "outputs in reset",
              64'({fs, sdo, sclk}), 64'(0));
        check(play_out == '0, "R1", "playback in reset", 64'(play_out), 64'(0));
        rst = 1'b0;
        repeat (100) @(negedge clk);
        check(slot_total == 0, "R1", "no frame sync before start", 64'(slot_total), 64'(0));
        push_round(0);
        start = 1'b1;
        repeat (2*HALF_CLKS + 1) @(negedge clk);
        check(slot_total == 1, "R2", "first frame sync after start", 64'(slot_total), 64'(1));
        for (int r = 1; r < NR; r++) begin
            wait (master_count == r);
            @(negedge clk);
            push_round(r);
            if (r == 3) start = 1'b0;   // R2: start dropped mid-run is ignored
        end
        wait (words_done == NR*NCH);
        @(negedge clk);
        check(exp_q.size() == 0, "R6", "all rounds delivered", 64'(exp_q.size()), 64'(0));
        check(stable_bad == 0, "R7", "fs/sdo moved off the rising edge", 64'(stable_bad), 64'(0));
        check(spacing_bad == 0, "R9", "bit clock period", 64'(spacing_bad), 64'(0));
        check(gap_sdo_bad == 0, "R3", "sdo in idle tail", 64'(gap_sdo_bad), 64'(0));
        check(fs_data_bad == 0, "R3", "fs during data bits", 64'(fs_data_bad), 64'(0));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(fs == 1'b0 && sdo == 1'b0 && play_out == '0, "R1", "reset mid-run",
              64'(play_out), 64'(0));
        done = 1'b1;
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d words", words_done, NR*NCH);
            summary();
            $finish;
        end
    end
endmodule